// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block decides whether an incoming frame with a group (multicast) destination address should be kept. The six destination address bytes arrive one per clock on a byte-serial input. A start strobe marks the beginning of each address. The block runs a CRC over those bytes as they arrive. Six bits of the final CRC remainder form an index. That index selects one bit of a 64-bit table, and the bit decides the verdict.

Software programs the table through a small register port. The port has eight byte-wide registers, and together they form the 64-bit table as an 8x8 matrix. One cycle after the sixth address byte is taken, the block raises a done pulse. In that cycle it also reports whether the address was multicast and whether it was accepted. Unicast matching, broadcast policy, frame storage and the frame check sequence are handled elsewhere.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all eight table registers read 0x00, and `done_o`, `accept_o` and `is_mcast_o` are 0. As a result, every multicast address is rejected until software sets a table bit.
- R2: A write with `reg_we_i` high stores `reg_wdata_i` into the register selected by `reg_addr_i` (0 to 7). `reg_rdata_o` shows the selected register combinationally. Writing one register leaves the others unchanged.
- R3: The lookup index is the six least significant bits of a CRC-32 remainder. The CRC uses polynomial 0x04C11DB7 and is preset to all ones. It runs over the six address bytes in arrival order, each byte least significant bit first, and takes no final inversion.
- R4: Index bits [5:3] pick the table register and index bits [2:0] pick the bit inside it. The 64-bit table is register 7 (most significant) down to register 0. A multicast address is accepted exactly when the selected bit is 1.
- R5: An address is multicast when bit 0 of its first byte is 1. For any other address, `is_mcast_o` and `accept_o` stay 0 during the done cycle.
- R6: `done_o` is high for exactly one cycle. That cycle directly follows the clock edge at which the sixth address byte is taken. `accept_o` and `is_mcast_o` are valid only in that cycle and are 0 in every other cycle.
- R7: `addr_start_i` clears the CRC and the byte count, abandoning any partly received address. If `addr_valid_i` is high in the same cycle, that byte counts as the first byte of the new address.
- R8: Once six bytes have been taken, further valid bytes are ignored until the next start. They produce no further done pulse.
- R9: Cycles with `addr_valid_i` low between address bytes do not change the result.
- R10: A table write in the same cycle as the sixth address byte does not affect that lookup. It applies only to later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Table register write enable |
| reg_addr_i | input | 3 | Table register select |
| reg_wdata_i | input | 8 | Table register write data |
| reg_rdata_o | output | 8 | Selected table register contents |
| addr_start_i | input | 1 | Start of a new destination address |
| addr_valid_i | input | 1 | `addr_byte_i` holds an address byte |
| addr_byte_i | input | 8 | Destination address byte, first byte first |
| is_mcast_o | output | 1 | Address was multicast (done cycle only) |
| accept_o | output | 1 | Multicast address accepted (done cycle only) |
| done_o | output | 1 | Lookup result valid, one-cycle pulse |

## Verification
The verdict outputs are registered once. `done_o`, `accept_o` and `is_mcast_o` are therefore due in the cycle after the edge that takes the sixth byte. `reg_rdata_o` follows a register write in the cycle after the write edge and follows a change of the select input at once.

The bench runs a behavioural reference model that updates at each rising edge from the same sampled inputs. It compares every output against that model one nanosecond after each edge, so every result is checked in the exact cycle it is due. Directed phases cover gaps between bytes, restarts, surplus bytes and a write that coincides with a lookup. A stream of pseudo-random group addresses runs under several table patterns.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  // one byte, LSB first, MSB-aligned remainder
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [$clog2(NUM_REGS)-1:0] addr_i,
  input  logic [REG_W-1:0]            wdata_i,
  output logic [REG_W-1:0]            rdata_o,
  output logic [NUM_REGS*REG_W-1:0]   tbl_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      regs_q[r] <= '0;
      else if (we_i && addr_i == ($clog2(NUM_REGS))'(r)) regs_q[r] <= wdata_i;
    end
    assign tbl_o[r*REG_W +: REG_W] = regs_q[r];
  end

  assign rdata_o = regs_q[addr_i];
endmodule

// File: rtl/mhf_addr_crc.sv
module mhf_addr_crc import mhf_pkg::*; #(
  parameter int ADDR_BYTES = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        valid_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_nxt_o,
  output logic        last_o,
  output logic        mcast_o
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] CNT_END  = CW'(ADDR_BYTES);
  localparam logic [CW-1:0] CNT_LAST = CW'(ADDR_BYTES - 1);

  logic [31:0]   crc_q, base_crc;
  logic [CW-1:0] cnt_q, base_cnt;
  logic          first_q, consume;

  always_comb begin
    base_crc  = start_i ? '1 : crc_q;
    base_cnt  = start_i ? '0 : cnt_q;
    consume   = valid_i && (base_cnt < CNT_END);
    crc_nxt_o = crc_byte(base_crc, byte_i);
    mcast_o   = (base_cnt == '0) ? byte_i[0] : first_q;
    last_o    = consume && (base_cnt == CNT_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q   <= '1;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (consume) begin
      crc_q <= crc_nxt_o;
      cnt_q <= base_cnt + 1'b1;
      if (base_cnt == '0) first_q <= byte_i[0];
    end else if (start_i) begin
      crc_q <= '1;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter import mhf_pkg::*; #(
  parameter int NUM_REGS   = 8,
  parameter int REG_W      = 8,
  parameter int ADDR_BYTES = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_we_i,
  input  logic [$clog2(NUM_REGS)-1:0] reg_addr_i,
  input  logic [REG_W-1:0]            reg_wdata_i,
  output logic [REG_W-1:0]            reg_rdata_o,
  input  logic                        addr_start_i,
  input  logic                        addr_valid_i,
  input  logic [7:0]                  addr_byte_i,
  output logic                        is_mcast_o,
  output logic                        accept_o,
  output logic                        done_o
);
  localparam int TBL_BITS = NUM_REGS * REG_W;
  localparam int IDX_W    = $clog2(TBL_BITS);

  logic [TBL_BITS-1:0] tbl;
  logic [31:0]         crc_nxt;
  logic                last, mcast, hit;
  logic                done_q, acc_q, mc_q;

  mhf_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_table (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .tbl_o(tbl)
  );

  mhf_addr_crc #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
    .clk_i, .rst_ni,
    .start_i(addr_start_i), .valid_i(addr_valid_i), .byte_i(addr_byte_i),
    .crc_nxt_o(crc_nxt), .last_o(last), .mcast_o(mcast)
  );

  // table read uses pre-write contents
  assign hit = tbl[crc_nxt[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      mc_q   <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      done_q <= last;
      mc_q   <= last && mcast;
      acc_q  <= last && mcast && hit;
    end
  end

  assign done_o     = done_q;
  assign is_mcast_o = mc_q;
  assign accept_o   = acc_q;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [2:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       addr_start_i,
  input logic       addr_valid_i,
  input logic [7:0] addr_byte_i,
  input logic       is_mcast_o,
  input logic       accept_o,
  input logic       done_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_QUIET_OUTSIDE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!accept_o && !is_mcast_o)); // R6
  AST_ACCEPT_NEEDS_MCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> is_mcast_o); // R5
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(addr_valid_i)); // R6
  AST_READ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(reg_we_i) && $stable(reg_addr_i)) |-> $stable(reg_rdata_o)); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(reg_we_i) && reg_addr_i == $past(reg_addr_i)) |-> reg_rdata_o == $past(reg_wdata_i)); // R2
endmodule

bind mcast_hash_filter mhf_checker u_mhf_checker (.*);

// File: tb/mcast_hash_filter_test.sv
`timescale 1ns/1ps
module mcast_hash_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] ra = '0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       st = 1'b0, vl = 1'b0;
  logic [7:0] ab = '0;
  logic       mc, acc, dn;

  int checks = 0, failures = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  mcast_hash_filter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .addr_start_i(st), .addr_valid_i(vl), .addr_byte_i(ab),
    .is_mcast_o(mc), .accept_o(acc), .done_o(dn)
  );

  // behavioural reference
  byte unsigned m_tbl[8];
  logic [31:0]  m_crc;
  int           m_cnt;
  bit           m_first, e_dn, e_acc, e_mc;

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      bit top = r[31] ^ d[i];
      r = r << 1;
      if (top) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic int idx_of(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int k = 0; k < 6; k++) c = ref_crc(c, a[8*k +: 8]);
    return int'(c[5:0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_tbl[i]) m_tbl[i] = 0;
      m_crc = '1; m_cnt = 0; m_first = 0;
      e_dn = 0; e_acc = 0; e_mc = 0;
    end else begin
      e_dn = 0; e_acc = 0; e_mc = 0;
      if (st) begin m_crc = '1; m_cnt = 0; end
      if (vl && m_cnt < 6) begin
        m_crc = ref_crc(m_crc, ab);
        if (m_cnt == 0) m_first = ab[0];
        m_cnt++;
        if (m_cnt == 6) begin
          e_dn  = 1;
          e_mc  = m_first;
          e_acc = m_first && m_tbl[m_crc[5:3]][m_crc[2:0]];
        end
      end
      if (we) m_tbl[ra] = wd;
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("done", {7'd0, dn}, {7'd0, e_dn});
      chk("accept", {7'd0, acc}, {7'd0, e_acc});
      chk("mcast", {7'd0, mc}, {7'd0, e_mc});
      chk("rdata", rd, m_tbl[ra]);
    end
  end

  task automatic wr(input int r, input byte unsigned v);
    @(negedge clk); we = 1; ra = 3'(r); wd = v;
    @(negedge clk); we = 0;
  endtask

  task automatic fill(input byte unsigned v);
    for (int r = 0; r < 8; r++) wr(r, v);
  endtask

  // sends a six-byte address; merge puts the first byte in the start cycle
  task automatic frame(input logic [47:0] a, input int gap, input bit merge);
    int k = 0;
    @(negedge clk); st = 1;
    if (merge) begin vl = 1; ab = a[7:0]; k = 1; end else vl = 0;
    for (; k < 6; k++) begin
      for (int g = 0; g < gap; g++) begin @(negedge clk); st = 0; vl = 0; end
      @(negedge clk); st = 0; vl = 1; ab = a[8*k +: 8];
    end
    @(negedge clk); st = 0; vl = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [47:0] lf = 48'h0123_4567_89AB;
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    chk("rst done", {7'd0, dn}, 8'd0);
    chk("rst rdata", rd, 8'd0);
    rst_n = 1;
    for (int r = 0; r < 8; r++) begin @(negedge clk); ra = 3'(r); @(negedge clk); chk("rst reg", rd, 8'd0); end
    frame(48'h0000_0000_0001, 0, 0);   // multicast rejected with empty table

    tag = "R2";
    for (int r = 0; r < 8; r++) wr(r, byte'(8'h11 * (r + 1)));
    for (int r = 0; r < 8; r++) begin @(negedge clk); ra = 3'(r); end
    wr(3, 8'hC3);

    tag = "R5";
    fill(8'hFF);
    frame(48'h5E00_0001_0000, 0, 0);   // first byte 00: unicast
    frame(48'h5E00_0001_0002, 1, 0);   // first byte 02: unicast

    tag = "R4";
    frame(48'h5E00_0001_0001, 0, 0);   // all ones: accepted
    begin
      int ix = idx_of(48'h5E00_0001_0001);
      wr(ix / 8, byte'(~(8'd1 << (ix % 8))));
      frame(48'h5E00_0001_0001, 0, 0); // only its bit cleared: rejected
    end

    tag = "R3";
    foreach (m_tbl[i]) ;
    for (int p = 0; p < 4; p++) begin
      fill(p == 0 ? 8'h55 : p == 1 ? 8'hA5 : p == 2 ? 8'h0F : 8'h81);
      wr(p, 8'h3C);
      for (int n = 0; n < 25; n++) begin
        lf = {lf[46:0], lf[47] ^ lf[42]} ^ 48'h0000_0000_0100;
        frame(lf | 48'h1, 0, 0);
      end
    end

    tag = "R9";
    frame(48'hFFEE_DDCC_BB01, 2, 0);
    frame(48'h1234_5678_9A03, 3, 0);

    tag = "R7";
    @(negedge clk); st = 1; vl = 0;
    for (int k = 0; k < 3; k++) begin @(negedge clk); st = 0; vl = 1; ab = 8'h10 + 8'(k); end
    @(negedge clk); vl = 0;
    frame(48'hAABB_CCDD_EE01, 0, 0);   // restart abandons partial address
    frame(48'h0102_0304_0507, 0, 1);   // start and first byte together

    tag = "R8";
    frame(48'h0A0B_0C0D_0E0F, 0, 0);
    for (int k = 0; k < 8; k++) begin @(negedge clk); vl = 1; ab = 8'(k); end
    @(negedge clk); vl = 0;
    repeat (3) @(negedge clk);

    tag = "R10";
    fill(8'hFF);
    begin
      logic [47:0] a = 48'h9988_7766_5501;
      int ix = idx_of(a);
      @(negedge clk); st = 1; vl = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); st = 0; vl = 1; ab = a[8*k +: 8];
        if (k == 5) begin we = 1; ra = 3'(ix / 8); wd = 8'h00; end
      end
      @(negedge clk); vl = 0; we = 0;
      repeat (2) @(negedge clk);
      frame(a, 0, 0);                  // now rejected
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule